// File: doc/BRIEF.md
# Interrupt Status Aggregator

This block gathers the pending-event flags of an audio controller into one 32-bit interrupt status word and drives a single level-sensitive interrupt line. It keeps the sticky status of three kinds of source: a two-flag response ring (response-ready and overrun), a bank of codec state-change flags that count toward the interrupt only where a matching wake-enable bit is set, and a small status nibble for each stream descriptor. Every source raises its flags with one-cycle set pulses. Software clears flags by writing ones, and each status register has its own clear mask.

The status word is formed combinationally. Bit i follows the buffer-completion flag of stream i. Bit 30 summarises the controller-side sources. Bit 31 is set when any other status bit is set. The interrupt line is registered. It is driven high only when the global-enable bit (control bit 31) is set and the status word, without its summary bit, shares a set bit with the control register.

Software reaches the control register, the wake-enable mask and the three clearable status groups through a single write port, selected by a 3-bit code. The sticky status of every source is visible on outputs.

Top module: `irq_aggregator`

## Requirements
- R1: After synchronous reset, the interrupt line, the status word, and all ring, codec and stream status outputs read zero.
- R2: A one-cycle set pulse on any source input sets the matching sticky status bit at the next clock edge. The bit then stays set until a clear write or a reset. Stream nibble layout: bit 0 buffer complete, bit 1 FIFO error, bit 2 descriptor error, bit 3 FIFO ready. Ring layout: bit 0 response ready, bit 1 overrun.
- R3: For each stream i (0 to NUM_STREAMS-1), status bit i equals that stream's buffer-complete flag. Status bits NUM_STREAMS to 29 read zero.
- R4: Status bit 30 is set when either ring flag is set, or when the bitwise AND of the codec state-change flags and the wake-enable mask is nonzero.
- R5: Status bit 31 is set exactly when any of status bits 0 to 30 is set.
- R6: The interrupt line takes, one clock after the edge in question, the value of (control bit 31) AND (status bits 0..30 AND control bits 0..30 is nonzero), as both stood before that edge.
- R7: A write with select 2 clears each of the 15 codec state-change flags whose data bit is one. Data bits above bit 14 have no effect.
- R8: A write with select 3 clears each ring flag whose data bit (bit 0 or 1) is one. The other ring flag is kept.
- R9: A write with select 4 and stream index k clears, in stream k only, the status bits 0 to 2 whose data bit is one. The FIFO-ready bit (bit 3) is never cleared by a write.
- R10: When a set pulse and a clearing write hit the same status bit in the same cycle, the bit is set afterwards.
- R11: Codec flags latch whatever the wake-enable mask holds (select 1 writes the mask from data bits 0..14). Only the gating into status bit 30 depends on the mask.
- R12: The summary bit 31 never takes part in the enable check: with the control register holding only bit 31, the line stays low whatever the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_set | input | 2 | Set pulses for ring flags (bit 0 response ready, bit 1 overrun) |
| codec_set | input | NUM_CODECS | Set pulses for codec state-change flags |
| stream_set | input | 4*NUM_STREAMS | Set pulses, one 4-bit nibble per stream |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write target: 0 control, 1 wake mask, 2 codec clear, 3 ring clear, 4 stream clear |
| wr_idx | input | IDX_W | Stream index for a select-4 write |
| wr_data | input | 32 | Write data or clear mask |
| irq | output | 1 | Registered level interrupt line |
| int_status | output | 32 | Combinational interrupt status word |
| ring_status | output | 2 | Sticky ring flags |
| codec_status | output | NUM_CODECS | Sticky codec state-change flags |
| stream_status | output | 4*NUM_STREAMS | Sticky stream status nibbles |

## Verification
A corrupted sticky flag shows up in the same cycle on its status output and in the status word. It then shows on the interrupt line exactly one clock later, if the flag is enabled. The wake mask and the control register have no output of their own, so a wrong value in either appears only through bit 30 or through the interrupt line. The bench therefore checks both on every cycle, against a reference that receives the same write stream. A clear mask that reaches the wrong stream, or that reaches the FIFO-ready bit, shows up on the stream status output one cycle after the write.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int STAT_W     = 32;
    localparam int CTRL_BIT   = 30;
    localparam int GLOBAL_BIT = 31;
    localparam int RING_W     = 2;

    // stream status nibble layout
    localparam int SS_W       = 4;
    localparam int SS_DONE    = 0;
    localparam int SS_FIFOERR = 1;
    localparam int SS_DESCERR = 2;
    localparam int SS_FREADY  = 3;

    typedef enum logic [2:0] {
        SEL_CTRL   = 3'd0,
        SEL_WAKE   = 3'd1,
        SEL_CODEC  = 3'd2,
        SEL_RING   = 3'd3,
        SEL_STREAM = 3'd4
    } wsel_e;

    typedef struct packed {
        logic              en;
        wsel_e             sel;
        logic [STAT_W-1:0] data;
    } wr_req_t;

    // bits of a stream nibble that a write may clear
    function automatic logic [SS_W-1:0] stream_clr_mask();
        logic [SS_W-1:0] m;
        m = '0;
        m[SS_DONE]    = 1'b1;
        m[SS_FIFOERR] = 1'b1;
        m[SS_DESCERR] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/w1c_bank.sv
module w1c_bank #(
    parameter int          W        = 4,
    parameter logic [W-1:0] CLR_MASK = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic         clr_en,
    input  logic [W-1:0] clr_data,
    output logic [W-1:0] q
);
    logic [W-1:0] clr_bits;

    always_comb begin
        clr_bits = clr_en ? (clr_data & CLR_MASK) : '0;
    end

    // a set pulse wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q & ~clr_bits) | set_i;
    end
endmodule

// File: rtl/status_combine.sv
module status_combine
    import irq_agg_pkg::*;
#(
    parameter int NUM_STREAMS = 8,
    parameter int NUM_CODECS  = 15
) (
    input  logic [NUM_STREAMS-1:0] stream_done,
    input  logic [RING_W-1:0]      ring_q,
    input  logic [NUM_CODECS-1:0]  codec_q,
    input  logic [NUM_CODECS-1:0]  wake_q,
    output logic [STAT_W-1:0]      status
);
    logic ctrl_src;

    always_comb begin
        ctrl_src = (|ring_q) | (|(codec_q & wake_q));
        status   = '0;
        for (int i = 0; i < NUM_STREAMS; i++) begin
            status[i] = stream_done[i];
        end
        status[CTRL_BIT]   = ctrl_src;
        status[GLOBAL_BIT] = ctrl_src | (|stream_done);
    end
endmodule

// File: rtl/irq_gate.sv
module irq_gate
    import irq_agg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [STAT_W-1:0] status,
    input  logic [STAT_W-1:0] ctrl,
    output logic              irq
);
    logic [GLOBAL_BIT-1:0] hit;

    always_comb begin
        hit = status[GLOBAL_BIT-1:0] & ctrl[GLOBAL_BIT-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= ctrl[GLOBAL_BIT] & (|hit);
    end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int  NUM_STREAMS = 8,
    parameter int  NUM_CODECS  = 15,
    localparam int IDX_W       = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1,
    localparam int SSV_W       = NUM_STREAMS * SS_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [RING_W-1:0]     ring_set,
    input  logic [NUM_CODECS-1:0] codec_set,
    input  logic [SSV_W-1:0]      stream_set,
    input  logic                  wr_en,
    input  logic [2:0]            wr_sel,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [STAT_W-1:0]     wr_data,
    output logic                  irq,
    output logic [STAT_W-1:0]     int_status,
    output logic [RING_W-1:0]     ring_status,
    output logic [NUM_CODECS-1:0] codec_status,
    output logic [SSV_W-1:0]      stream_status
);
    localparam logic [SS_W-1:0] SCLR = stream_clr_mask();

    wr_req_t                req;
    logic [STAT_W-1:0]      ctrl_q;
    logic [NUM_CODECS-1:0]  wake_q;
    logic [NUM_STREAMS-1:0] done_vec;

    always_comb begin
        req.en   = wr_en;
        req.sel  = wsel_e'(wr_sel);
        req.data = wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            wake_q <= '0;
        end else if (req.en) begin
            if (req.sel == SEL_CTRL) ctrl_q <= req.data;
            if (req.sel == SEL_WAKE) wake_q <= req.data[NUM_CODECS-1:0];
        end
    end

    w1c_bank #(.W(RING_W), .CLR_MASK('1)) u_ring (
        .clk(clk), .rst(rst), .set_i(ring_set),
        .clr_en(req.en && req.sel == SEL_RING),
        .clr_data(req.data[RING_W-1:0]), .q(ring_status)
    );

    w1c_bank #(.W(NUM_CODECS), .CLR_MASK('1)) u_codec (
        .clk(clk), .rst(rst), .set_i(codec_set),
        .clr_en(req.en && req.sel == SEL_CODEC),
        .clr_data(req.data[NUM_CODECS-1:0]), .q(codec_status)
    );

    for (genvar i = 0; i < NUM_STREAMS; i++) begin : g_stream
        logic [SS_W-1:0] nib;
        w1c_bank #(.W(SS_W), .CLR_MASK(SCLR)) u_bank (
            .clk(clk), .rst(rst), .set_i(stream_set[i*SS_W +: SS_W]),
            .clr_en(req.en && req.sel == SEL_STREAM && wr_idx == IDX_W'(i)),
            .clr_data(req.data[SS_W-1:0]), .q(nib)
        );
        assign stream_status[i*SS_W +: SS_W] = nib;
        assign done_vec[i] = nib[SS_DONE];
    end

    status_combine #(.NUM_STREAMS(NUM_STREAMS), .NUM_CODECS(NUM_CODECS)) u_comb (
        .stream_done(done_vec), .ring_q(ring_status),
        .codec_q(codec_status), .wake_q(wake_q), .status(int_status)
    );

    irq_gate u_gate (
        .clk(clk), .rst(rst), .status(int_status), .ctrl(ctrl_q), .irq(irq)
    );
endmodule

// File: rtl/irq_agg_checker.sv
module irq_agg_checker
    import irq_agg_pkg::*;
#(
    parameter int NUM_STREAMS = 8,
    parameter int NUM_CODECS  = 15
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        irq,
    input logic [STAT_W-1:0]           int_status,
    input logic [RING_W-1:0]           ring_status,
    input logic [RING_W-1:0]           ring_set,
    input logic [NUM_CODECS-1:0]       codec_status,
    input logic [NUM_CODECS-1:0]       wake_q,
    input logic [STAT_W-1:0]           ctrl_q,
    input logic [NUM_STREAMS*SS_W-1:0] stream_status
);
    logic [NUM_STREAMS-1:0] done_bits;
    logic [NUM_STREAMS-1:0] fready_bits;
    logic                   line_next;

    always_comb begin
        for (int i = 0; i < NUM_STREAMS; i++) begin
            done_bits[i]   = stream_status[i*SS_W + SS_DONE];
            fready_bits[i] = stream_status[i*SS_W + SS_FREADY];
        end
        line_next = ctrl_q[GLOBAL_BIT] &&
                    ((int_status[GLOBAL_BIT-1:0] & ctrl_q[GLOBAL_BIT-1:0]) != '0);
    end

    assert_irq_low_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !irq);

    assert_stream_bits_R3: assert property (@(posedge clk) disable iff (rst)
        int_status[NUM_STREAMS-1:0] == done_bits);

    assert_ctrl_bit_R4: assert property (@(posedge clk) disable iff (rst)
        int_status[CTRL_BIT] == ((|ring_status) || ((codec_status & wake_q) != '0)));

    assert_summary_R5: assert property (@(posedge clk) disable iff (rst)
        int_status[GLOBAL_BIT] == ((|done_bits) || (|ring_status) || ((codec_status & wake_q) != '0)));

    assert_irq_timing_R6: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (irq == $past(line_next)));

    assert_fready_kept_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((fready_bits & $past(fready_bits)) == $past(fready_bits)));

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((ring_status & $past(ring_set)) == $past(ring_set)));
endmodule

bind irq_aggregator irq_agg_checker #(.NUM_STREAMS(NUM_STREAMS), .NUM_CODECS(NUM_CODECS)) u_chk (
    .clk(clk), .rst(rst), .irq(irq), .int_status(int_status),
    .ring_status(ring_status), .ring_set(ring_set), .codec_status(codec_status),
    .wake_q(wake_q), .ctrl_q(ctrl_q), .stream_status(stream_status)
);

// File: tb/tb_irq_aggregator.sv
module tb_irq_aggregator;
    localparam int NS = 8;
    localparam int NC = 15;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  ring_set = '0;
    logic [NC-1:0] codec_set = '0;
    logic [NS*4-1:0] stream_set = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [2:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        irq;
    logic [31:0] int_status;
    logic [1:0]  ring_status;
    logic [NC-1:0] codec_status;
    logic [NS*4-1:0] stream_status;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    irq_aggregator #(.NUM_STREAMS(NS), .NUM_CODECS(NC)) dut (
        .clk(clk), .rst(rst), .ring_set(ring_set), .codec_set(codec_set),
        .stream_set(stream_set), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
        .wr_data(wr_data), .irq(irq), .int_status(int_status),
        .ring_status(ring_status), .codec_status(codec_status),
        .stream_status(stream_status)
    );

    // ---------------- behavioural reference ----------------
    bit [3:0]  m_str [NS];
    bit [1:0]  m_ring;
    bit [NC-1:0] m_codec, m_wake;
    bit [31:0] m_ctrl;
    bit        m_irq;

    function automatic bit [31:0] m_status();
        bit [31:0] s = 0;
        bit any = 0;
        for (int i = 0; i < NS; i++) if (m_str[i][0]) begin s[i] = 1; any = 1; end
        if (m_ring != 0 || (m_codec & m_wake) != 0) begin s[30] = 1; any = 1; end
        s[31] = any;
        return s;
    endfunction

    function automatic bit [31:0] m_streams();
        bit [31:0] v = 0;
        for (int i = 0; i < NS; i++) v[i*4 +: 4] = m_str[i];
        return v;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NS; i++) m_str[i] = 0;
            m_ring = 0; m_codec = 0; m_wake = 0; m_ctrl = 0; m_irq = 0;
        end else begin
            m_irq = m_ctrl[31] && ((m_status() & m_ctrl & 32'h7FFF_FFFF) != 0);
            if (wr_en) begin
                case (wr_sel)
                    3'd0: m_ctrl = wr_data;
                    3'd1: m_wake = wr_data[NC-1:0];
                    3'd2: m_codec = m_codec & ~wr_data[NC-1:0];
                    3'd3: m_ring = m_ring & ~wr_data[1:0];
                    3'd4: m_str[wr_idx] = m_str[wr_idx] & ~(wr_data[3:0] & 4'b0111);
                    default: ;
                endcase
            end
            m_ring  = m_ring | ring_set;
            m_codec = m_codec | codec_set;
            for (int i = 0; i < NS; i++) m_str[i] = m_str[i] | stream_set[i*4 +: 4];
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the reference
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R6 irq vs model", {31'd0, irq}, {31'd0, m_irq});
            chk("R5 status vs model", int_status, m_status());
            chk("R8 ring vs model", {30'd0, ring_status}, {30'd0, m_ring});
            chk("R7 codec vs model", {17'd0, codec_status}, {17'd0, m_codec});
            chk("R9 streams vs model", stream_status, m_streams());
        end
    end

    task automatic idle();
        ring_set = '0; codec_set = '0; stream_set = '0;
        wr_en = 1'b0; wr_sel = '0; wr_idx = '0; wr_data = '0;
    endtask

    task automatic step();
        @(negedge clk);
        idle();
    endtask

    task automatic wr(input logic [2:0] sel, input logic [2:0] idx, input logic [31:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_idx = idx; wr_data = d;
        step();
    endtask

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 status", int_status, 32'd0);
        chk("R1 streams", stream_status, 32'd0);
        chk("R1 ring/codec", {15'd0, codec_status, ring_status}, 32'd0);

        // R2 R3 R5: stream 2 completion plus FIFO ready
        stream_set[2*4+0] = 1'b1; stream_set[2*4+3] = 1'b1;
        step();
        chk("R2 stream latch", stream_status, 32'h0000_0900);
        chk("R3 R5 status", int_status, 32'h8000_0004);

        // R6: enable stream 2, line rises one cycle after the control write
        wr(3'd0, 3'd0, 32'h8000_0004);
        chk("R6 line not yet", {31'd0, irq}, 32'd0);
        step();
        chk("R6 line high", {31'd0, irq}, 32'd1);

        // R9: clear all of stream 2, FIFO ready survives
        wr(3'd4, 3'd2, 32'hFFFF_FFFF);
        chk("R9 fifo ready kept", stream_status, 32'h0000_0800);
        chk("R9 status clear", int_status, 32'd0);
        chk("R6 line lags clear", {31'd0, irq}, 32'd1);
        step();
        chk("R6 line falls", {31'd0, irq}, 32'd0);

        // R11: codec flag latches but is gated by wake
        codec_set = 15'h0020;
        step();
        chk("R11 codec latched", {17'd0, codec_status}, 32'h20);
        chk("R11 gated out", int_status, 32'd0);
        wr(3'd1, 3'd0, 32'h0000_0020);
        chk("R4 wake gated in", int_status, 32'hC000_0000);
        step();
        chk("R6 not enabled", {31'd0, irq}, 32'd0);

        // R7: clear codec with over-wide data
        wr(3'd2, 3'd0, 32'hFFFF_FFFF);
        chk("R7 codec cleared", {17'd0, codec_status}, 32'd0);
        chk("R7 status", int_status, 32'd0);

        // R4 R8: ring overrun
        ring_set = 2'b10;
        step();
        chk("R4 ring flag", int_status, 32'hC000_0000);
        wr(3'd3, 3'd0, 32'h1);
        chk("R8 other flag kept", {30'd0, ring_status}, 32'h2);
        wr(3'd3, 3'd0, 32'h2);
        chk("R8 flag cleared", {30'd0, ring_status}, 32'h0);

        // R10: set and clear together
        ring_set = 2'b01;
        wr(3'd3, 3'd0, 32'h1);
        chk("R10 set wins", {30'd0, ring_status}, 32'h1);

        // R12: summary bit alone never enables
        wr(3'd0, 3'd0, 32'h8000_0000);
        step();
        chk("R12 summary excluded", {31'd0, irq}, 32'd0);
        wr(3'd0, 3'd0, 32'h4000_0000);
        step();
        chk("R6 no global enable", {31'd0, irq}, 32'd0);
        wr(3'd0, 3'd0, 32'hC000_0000);
        step();
        chk("R6 ctrl source enabled", {31'd0, irq}, 32'd1);

        // random traffic, compared every clock
        for (int n = 0; n < 3000; n++) begin
            ring_set   = (($urandom % 8) == 0) ? 2'($urandom) : 2'b00;
            codec_set  = (($urandom % 6) == 0) ? NC'($urandom) & NC'($urandom) : '0;
            stream_set = (($urandom % 4) == 0) ? $urandom & $urandom & $urandom : '0;
            wr_en      = ($urandom % 3) == 0;
            wr_sel     = 3'($urandom % 5);
            wr_idx     = 3'($urandom);
            wr_data    = $urandom;
            @(negedge clk);
        end
        idle();
        @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule